// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Monitor

The monitor sits beside a single-data-rate SDRAM command bus with four banks and samples the control lines on every rising clock edge. It turns each sample into one decoded command. It follows which banks have a row open and which row that is. It checks every command against a set of minimum-spacing and state rules, each counted in whole clocks. It does not drive the bus. A controller under test, or a bus model, shares the pins with it. The monitor reports each rule that the bus breaks.

Each command is decoded from chip select, the three strobes and the clock enable, as sampled at the current edge and at the edge before. The monitor keeps a per-bank record of open or closed state, the open row, and the clocks elapsed since the last activate, precharge and write data. It also holds the burst length programmed by the last mode register write, the mode register lockout and the self-refresh state. A broken rule sets a sticky bit and raises a one-clock error pulse that carries a code.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded with chip select low from {rasN,casN,weN}: 000 mode set (cmdOut 9), 001 refresh, 011 activate (1), 101 read (2), 100 write (3), 010 precharge (4, or precharge-all 5 when addr[10] is 1), 110 burst stop (8), 111 NOP (0). cmdOut shows the decoded command one clock after the sampling edge. Chip select high yields NOP with no state change.
- R2: An activate opens bank ba (ba=0..3), sets bankActive[ba], and stores addr in openRows[12*ba +: 12].
- R3: A precharge with addr[10]=0 closes only bank ba. With addr[10]=1 it closes every open bank and ignores ba.
- R4: A refresh with cke high is auto refresh (cmdOut 6). A refresh sampled with cke low after a high sample enters self refresh (cmdOut 7). While self refresh holds, and on the edge where cke returns high, every command is ignored. Any non-NOP within TRC clocks of that edge raises code 11. A sample taken when the previous cke was low is ignored.
- R5: A read or write to a closed bank raises code 9. A read or write fewer than TRCD clocks after that bank's activate raises code 1.
- R6: An activate raises code 10 if its bank is open, code 2 if fewer than TRP clocks have passed since the bank closed, and code 4 if fewer than TRC clocks have passed since the bank's last activate. It raises code 5 if it falls fewer than TRRD clocks after an activate to a different bank.
- R7: A precharge of an open bank raises code 3 if fewer than TRAS clocks have passed since its activate. It raises code 6 if fewer than TRDL clocks have passed since that bank's last write data beat. A write's data lasts the programmed burst length: mode-set addr[2:0] of 0,1,2,3 gives 1,2,4,8, and any other value gives 1. Mode-set addr[9]=1 forces a write length of 1.
- R8: A mode set, an auto refresh or a self-refresh entry while any bank is open raises code 7.
- R9: Any non-NOP command fewer than 2 clocks after a mode set raises code 8.
- R10: A read or write with addr[10]=1 closes its bank by itself. A read closes it burst length clocks after the command. A write closes it write length - 1 + TRDL clocks after the command. TRP counts from that closing edge.
- R11: Each violated code k sets errSticky[k-1], which only reset clears. errPulse is high for one clock after a violating command. errCode shows the lowest-numbered code violated by that command, and 0 when no code is violated. Every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable line |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Multiplexed address bus |
| cmdOut | output | 4 | Decoded command of the last edge |
| bankActive | output | 4 | One bit per bank, 1 when a row is open |
| openRows | output | 48 | Open row of each bank, 12 bits per bank |
| errPulse | output | 1 | One-clock violation flag |
| errCode | output | 4 | Lowest violated code of the last edge |
| errSticky | output | 11 | Accumulated violations, bit k-1 for code k |

## Verification
A bank whose open flag or spacing counter is wrong shows up in one of two ways. The bank may light or clear in bankActive on the wrong edge. A later command may draw a false or missing code, often many clocks after the fault itself, for example when an auto precharge closes a bank one clock late. For that reason the bench compares every output on every clock against a reference that counts in absolute cycle numbers. A wrong self-refresh or lockout state appears at once on cmdOut as a command that should have been ignored, or the reverse.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;
  localparam int BANKS       = 4;
  localparam int BANK_W      = 2;
  localparam int ADDR_W      = 12;
  localparam int AP_BIT      = 10;
  localparam int WSINGLE_BIT = 9;
  localparam int NUM_ERR     = 11;
  localparam int CODE_W      = 4;

  typedef enum logic [3:0] {
    CMD_NOP = 4'd0, CMD_ACT = 4'd1, CMD_READ = 4'd2, CMD_WRITE = 4'd3,
    CMD_PRE = 4'd4, CMD_PREALL = 4'd5, CMD_AREF = 4'd6, CMD_SREF = 4'd7,
    CMD_BSTOP = 4'd8, CMD_MRS = 4'd9
  } cmd_e;

  localparam int ERR_RCD  = 1;
  localparam int ERR_RP   = 2;
  localparam int ERR_RAS  = 3;
  localparam int ERR_RC   = 4;
  localparam int ERR_RRD  = 5;
  localparam int ERR_RDL  = 6;
  localparam int ERR_BUSY = 7;
  localparam int ERR_LOCK = 8;
  localparam int ERR_IDLE = 9;
  localparam int ERR_OPEN = 10;
  localparam int ERR_EXIT = 11;

  // Strobe bundle from control to the bank datapath
  typedef struct packed {
    cmd_e              cmd;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
  } strobe_t;
endpackage

// File: rtl/sdmon_ctrl.sv
module sdmon_ctrl import sdmon_pkg::*; #(
  parameter int TRC     = 7,
  parameter int MRS_GAP = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cke,
  input  logic               csN,
  input  logic               rasN,
  input  logic               casN,
  input  logic               weN,
  input  logic [BANK_W-1:0]  ba,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_ERR-1:0] dpErr,
  output strobe_t            stb,
  output cmd_e               cmdQ,
  output logic               errPulse,
  output logic [CODE_W-1:0]  errCode,
  output logic [NUM_ERR-1:0] errSticky
);
  localparam int CNT_W = $clog2(TRC + MRS_GAP + 1);

  logic ckePrev, selfRef;
  logic [CNT_W-1:0] exitCnt, mrsCnt;
  cmd_e rawCmd, effCmd;
  logic [NUM_ERR-1:0] allErr;
  logic [CODE_W-1:0] firstCode;

  always_comb begin
    rawCmd = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b000:  rawCmd = CMD_MRS;
        3'b001:  rawCmd = cke ? CMD_AREF : CMD_SREF;
        3'b011:  rawCmd = CMD_ACT;
        3'b101:  rawCmd = CMD_READ;
        3'b100:  rawCmd = CMD_WRITE;
        3'b010:  rawCmd = addr[AP_BIT] ? CMD_PREALL : CMD_PRE;
        3'b110:  rawCmd = CMD_BSTOP;
        default: rawCmd = CMD_NOP;
      endcase
    end
    effCmd = (selfRef || !ckePrev) ? CMD_NOP : rawCmd;
  end

  always_comb begin
    stb.cmd  = effCmd;
    stb.bank = ba;
    stb.addr = addr;
  end

  always_comb begin
    allErr = dpErr;
    allErr[ERR_LOCK-1] = (mrsCnt != '0) && (effCmd != CMD_NOP);
    allErr[ERR_EXIT-1] = (exitCnt != '0) && (effCmd != CMD_NOP);
    firstCode = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--)
      if (allErr[i]) firstCode = CODE_W'(i + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev   <= 1'b1;
      selfRef   <= 1'b0;
      exitCnt   <= '0;
      mrsCnt    <= '0;
      cmdQ      <= CMD_NOP;
      errPulse  <= 1'b0;
      errCode   <= '0;
      errSticky <= '0;
    end else begin
      ckePrev   <= cke;
      cmdQ      <= effCmd;
      errPulse  <= |allErr;
      errCode   <= firstCode;
      errSticky <= errSticky | allErr;
      if (mrsCnt != '0) mrsCnt <= mrsCnt - 1'b1;
      if (effCmd == CMD_MRS) mrsCnt <= CNT_W'(MRS_GAP - 1);
      if (exitCnt != '0) exitCnt <= exitCnt - 1'b1;
      if (selfRef) begin
        if (cke) begin
          selfRef <= 1'b0;
          exitCnt <= CNT_W'(TRC - 1);
        end
      end else if (effCmd == CMD_SREF) begin
        selfRef <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdmon_bank_dp.sv
module sdmon_bank_dp import sdmon_pkg::*; #(
  parameter int TRCD = 2,
  parameter int TRP  = 2,
  parameter int TRAS = 5,
  parameter int TRC  = 7,
  parameter int TRRD = 2,
  parameter int TRDL = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  output logic [NUM_ERR-1:0]       dpErr,
  output logic [BANKS-1:0]         bankActive,
  output logic [BANKS*ADDR_W-1:0]  openRows
);
  localparam int MAX_BURST = 8;
  localparam int LEN_W     = $clog2(MAX_BURST) + 1;
  localparam int SPAN      = TRCD + TRP + TRAS + TRC + TRRD + TRDL + MAX_BURST;
  localparam int CNT_W     = $clog2(SPAN + 1);

  logic [LEN_W-1:0]  rdLen, wrLen, mrsLen;
  logic [CNT_W-1:0]  rrdCnt;
  logic [BANK_W-1:0] lastAct;
  logic isAccess, isAct, isPreAll, isPreOne, eRrd, eBusy;
  logic [BANKS-1:0] eRcd, eIdle, eOpen, eRp, eRc, eRas, eRdl;

  assign isAccess = (stb.cmd == CMD_READ) || (stb.cmd == CMD_WRITE);
  assign isAct    = (stb.cmd == CMD_ACT);
  assign isPreAll = (stb.cmd == CMD_PREALL);
  assign isPreOne = (stb.cmd == CMD_PRE);
  assign eRrd  = isAct && (rrdCnt != '0) && (stb.bank != lastAct);
  assign eBusy = ((stb.cmd == CMD_MRS) || (stb.cmd == CMD_AREF) ||
                  (stb.cmd == CMD_SREF)) && (|bankActive);

  always_comb begin
    case (stb.addr[2:0])
      3'd1:    mrsLen = LEN_W'(2);
      3'd2:    mrsLen = LEN_W'(4);
      3'd3:    mrsLen = LEN_W'(8);
      default: mrsLen = LEN_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLen   <= LEN_W'(1);
      wrLen   <= LEN_W'(1);
      rrdCnt  <= '0;
      lastAct <= '0;
    end else begin
      if (rrdCnt != '0) rrdCnt <= rrdCnt - 1'b1;
      if (isAct) begin
        rrdCnt  <= CNT_W'(TRRD - 1);
        lastAct <= stb.bank;
      end
      if (stb.cmd == CMD_MRS) begin
        rdLen <= mrsLen;
        wrLen <= stb.addr[WSINGLE_BIT] ? LEN_W'(1) : mrsLen;
      end
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic active, apPend;
    logic [ADDR_W-1:0] row;
    logic [CNT_W-1:0] rcdCnt, rasCnt, rcCnt, rpCnt, wrCnt, apCnt;
    logic mine, accessHit, actHit, preHit, apFire;

    assign mine      = (stb.bank == BANK_W'(g));
    assign accessHit = isAccess && mine;
    assign actHit    = isAct && mine;
    assign preHit    = (isPreOne && mine) || isPreAll;
    assign apFire    = apPend && (apCnt == '0);

    assign eIdle[g] = accessHit && !active;
    assign eRcd[g]  = accessHit && active && (rcdCnt != '0);
    assign eOpen[g] = actHit && active;
    assign eRp[g]   = actHit && (rpCnt != '0);
    assign eRc[g]   = actHit && (rcCnt != '0);
    assign eRas[g]  = preHit && active && (rasCnt != '0);
    assign eRdl[g]  = preHit && active && (wrCnt != '0);

    assign bankActive[g] = active;
    assign openRows[g*ADDR_W +: ADDR_W] = row;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active <= 1'b0;
        apPend <= 1'b0;
        row    <= '0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rcCnt  <= '0;
        rpCnt  <= '0;
        wrCnt  <= '0;
        apCnt  <= '0;
      end else begin
        if (rcdCnt != '0) rcdCnt <= rcdCnt - 1'b1;
        if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
        if (rcCnt  != '0) rcCnt  <= rcCnt - 1'b1;
        if (rpCnt  != '0) rpCnt  <= rpCnt - 1'b1;
        if (wrCnt  != '0) wrCnt  <= wrCnt - 1'b1;
        if (apPend && apCnt != '0) apCnt <= apCnt - 1'b1;
        if (apFire || (preHit && active)) begin
          active <= 1'b0;
          apPend <= 1'b0;
          rpCnt  <= CNT_W'(TRP - 1);
        end
        if (accessHit && active) begin
          if (stb.cmd == CMD_WRITE) wrCnt <= CNT_W'(int'(wrLen) + TRDL - 2);
          if (stb.addr[AP_BIT]) begin
            apPend <= 1'b1;
            apCnt  <= (stb.cmd == CMD_WRITE) ? CNT_W'(int'(wrLen) + TRDL - 2)
                                             : CNT_W'(int'(rdLen) - 1);
          end
        end
        if (actHit) begin
          active <= 1'b1;
          apPend <= 1'b0;
          row    <= stb.addr;
          rcdCnt <= CNT_W'(TRCD - 1);
          rasCnt <= CNT_W'(TRAS - 1);
          rcCnt  <= CNT_W'(TRC - 1);
        end
      end
    end
  end

  always_comb begin
    dpErr = '0;
    dpErr[ERR_RCD-1]  = |eRcd;
    dpErr[ERR_RP-1]   = |eRp;
    dpErr[ERR_RAS-1]  = |eRas;
    dpErr[ERR_RC-1]   = |eRc;
    dpErr[ERR_RRD-1]  = eRrd;
    dpErr[ERR_RDL-1]  = |eRdl;
    dpErr[ERR_BUSY-1] = eBusy;
    dpErr[ERR_IDLE-1] = |eIdle;
    dpErr[ERR_OPEN-1] = |eOpen;
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor import sdmon_pkg::*; #(
  parameter int TRCD    = 2,
  parameter int TRP     = 2,
  parameter int TRAS    = 5,
  parameter int TRC     = 7,
  parameter int TRRD    = 2,
  parameter int TRDL    = 2,
  parameter int MRS_GAP = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cke,
  input  logic         csN,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  input  logic [1:0]   ba,
  input  logic [11:0]  addr,
  output logic [3:0]   cmdOut,
  output logic [3:0]   bankActive,
  output logic [47:0]  openRows,
  output logic         errPulse,
  output logic [3:0]   errCode,
  output logic [10:0]  errSticky
);
  strobe_t stb;
  cmd_e cmdQ;
  logic [NUM_ERR-1:0] dpErr;

  sdmon_ctrl #(.TRC(TRC), .MRS_GAP(MRS_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .dpErr(dpErr), .stb(stb), .cmdQ(cmdQ),
    .errPulse(errPulse), .errCode(errCode), .errSticky(errSticky)
  );

  sdmon_bank_dp #(.TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRC(TRC),
                  .TRRD(TRRD), .TRDL(TRDL)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dpErr(dpErr),
    .bankActive(bankActive), .openRows(openRows)
  );

  assign cmdOut = cmdQ;
endmodule

// File: rtl/sdmon_checker.sv
module sdmon_checker import sdmon_pkg::*; (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   cmdOut,
  input logic [3:0]   bankActive,
  input logic         errPulse,
  input logic [3:0]   errCode,
  input logic [10:0]  errSticky
);
  // R11: sticky bits never clear outside reset
  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errSticky & $past(errSticky)) == $past(errSticky)));

  // R11: a pulse carries a nonzero code whose sticky bit is set
  assert_pulse_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ((errCode != 4'd0) &&
                  (|(errSticky & (11'd1 << (errCode - 4'd1))))));

  // R11: no pulse means no code
  assert_quiet_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> (errCode == 4'd0));

  // R2: a bank opens only on an activate
  assert_open_on_act_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(bankActive & ~$past(bankActive))) |-> (cmdOut == 4'(CMD_ACT)));

  // R2: at most one bank opens per clock
  assert_single_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(bankActive & ~$past(bankActive)) <= 1);

  // R9: a command right after a mode set is flagged
  assert_mrs_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 4'(CMD_MRS)) |=> ((cmdOut == 4'(CMD_NOP)) || errSticky[ERR_LOCK-1]));
endmodule

bind sdram_cmd_monitor sdmon_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdOut(cmdOut), .bankActive(bankActive),
  .errPulse(errPulse), .errCode(errCode), .errSticky(errSticky)
);

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;
  import sdmon_pkg::*;

  localparam int TRCD = 2, TRP = 2, TRAS = 5, TRC = 7, TRRD = 2, TRDL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [3:0] cmdOut, bankActive, errCode;
  logic [47:0] openRows;
  logic errPulse;
  logic [10:0] errSticky;

  always #4 clk = ~clk;

  sdram_cmd_monitor u0 (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdOut(cmdOut), .bankActive(bankActive),
    .openRows(openRows), .errPulse(errPulse), .errCode(errCode),
    .errSticky(errSticky)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // reference state, in absolute cycle numbers
  int cyc;
  bit mAct[4];
  logic [11:0] mRow[4];
  int tAct[4], tPre[4], tWrEnd[4], apAt[4];
  int tLastAct, lastBank, tMrs, tExit, rdL, wrL;
  bit srOn, ckeP;
  logic [3:0] eCmd, eCode;
  logic eP;
  logic [10:0] eSt;

  task automatic modelReset();
    cyc = 0; srOn = 0; ckeP = 1; rdL = 1; wrL = 1;
    tLastAct = -1000; lastBank = 0; tMrs = -1000; tExit = -1000;
    for (int b = 0; b < 4; b++) begin
      mAct[b] = 0; mRow[b] = '0; tAct[b] = -1000; tPre[b] = -1000;
      tWrEnd[b] = -1000; apAt[b] = -1;
    end
    eCmd = '0; eCode = '0; eP = 0; eSt = '0;
  endtask

  function automatic int lenOf(logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic modelStep();
    bit e[12];
    bit a0[4];
    bit anyOpen;
    cmd_e c;
    int b;
    cyc++;
    for (int i = 0; i < 12; i++) e[i] = 0;
    c = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b000: c = CMD_MRS;
        3'b001: c = cke ? CMD_AREF : CMD_SREF;
        3'b011: c = CMD_ACT;
        3'b101: c = CMD_READ;
        3'b100: c = CMD_WRITE;
        3'b010: c = addr[10] ? CMD_PREALL : CMD_PRE;
        3'b110: c = CMD_BSTOP;
        default: c = CMD_NOP;
      endcase
    end
    if (srOn || !ckeP) c = CMD_NOP;
    if (srOn && cke) begin srOn = 0; tExit = cyc; end
    b = int'(ba);
    anyOpen = 0;
    for (int i = 0; i < 4; i++) begin a0[i] = mAct[i]; anyOpen |= mAct[i]; end
    if (c != CMD_NOP) begin
      if (cyc - tMrs < 2) e[8] = 1;
      if (cyc - tExit < TRC) e[11] = 1;
    end
    if (c == CMD_READ || c == CMD_WRITE) begin
      if (!a0[b]) e[9] = 1;
      else if (cyc - tAct[b] < TRCD) e[1] = 1;
    end
    if (c == CMD_ACT) begin
      if (a0[b]) e[10] = 1;
      if (cyc - tPre[b] < TRP) e[2] = 1;
      if (cyc - tAct[b] < TRC) e[4] = 1;
      if (b != lastBank && cyc - tLastAct < TRRD) e[5] = 1;
    end
    for (int i = 0; i < 4; i++)
      if (((c == CMD_PRE && i == b) || c == CMD_PREALL) && a0[i]) begin
        if (cyc - tAct[i] < TRAS) e[3] = 1;
        if (cyc - tWrEnd[i] < TRDL) e[6] = 1;
      end
    if ((c == CMD_MRS || c == CMD_AREF || c == CMD_SREF) && anyOpen) e[7] = 1;
    // state effects
    for (int i = 0; i < 4; i++) begin
      if (apAt[i] == cyc || (((c == CMD_PRE && i == b) || c == CMD_PREALL) && a0[i])) begin
        mAct[i] = 0; tPre[i] = cyc; apAt[i] = -1;
      end
    end
    if ((c == CMD_READ || c == CMD_WRITE) && a0[b]) begin
      if (c == CMD_WRITE) tWrEnd[b] = cyc + wrL - 1;
      if (addr[10]) apAt[b] = cyc + ((c == CMD_WRITE) ? (wrL - 1 + TRDL) : rdL);
    end
    if (c == CMD_ACT) begin
      mAct[b] = 1; mRow[b] = addr; tAct[b] = cyc; tLastAct = cyc;
      lastBank = b; apAt[b] = -1;
    end
    if (c == CMD_MRS) begin
      tMrs = cyc; rdL = lenOf(addr[2:0]); wrL = addr[9] ? 1 : rdL;
    end
    if (c == CMD_SREF) srOn = 1;
    ckeP = cke;
    eCmd = 4'(c);
    eP = 0; eCode = '0;
    for (int k = 11; k >= 1; k--)
      if (e[k]) begin eP = 1; eCode = 4'(k); eSt[k-1] = 1'b1; end
  endtask

  task automatic chk(string req, string nm, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, nm, act, exp, cyc);
    end
  endtask

  task automatic compareAll(string req);
    logic [47:0] rows;
    logic [3:0] act4;
    for (int i = 0; i < 4; i++) begin
      rows[i*12 +: 12] = mRow[i];
      act4[i] = mAct[i];
    end
    chk(req, "cmdOut", 64'(cmdOut), 64'(eCmd));
    chk(req, "bankActive", 64'(bankActive), 64'(act4));
    chk(req, "openRows", 64'(openRows), 64'(rows));
    chk(req, "errPulse", 64'(errPulse), 64'(eP));
    chk(req, "errCode", 64'(errCode), 64'(eCode));
    chk(req, "errSticky", 64'(errSticky), 64'(eSt));
  endtask

  task automatic issue(string req, logic k, logic cs, logic [2:0] rcw,
                       logic [1:0] b, logic [11:0] a);
    cke = k; csN = cs; {rasN, casN, weN} = rcw; ba = b; addr = a;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll(req);
  endtask

  task automatic nops(string req, int n);
    for (int i = 0; i < n; i++) issue(req, 1'b1, 1'b0, 3'b111, 2'd0, 12'd0);
  endtask
  task automatic act(string req, logic [1:0] b, logic [11:0] r);
    issue(req, 1'b1, 1'b0, 3'b011, b, r);
  endtask
  task automatic rd(string req, logic [1:0] b, logic ap);
    issue(req, 1'b1, 1'b0, 3'b101, b, {1'b0, ap, 10'h015});
  endtask
  task automatic wr(string req, logic [1:0] b, logic ap);
    issue(req, 1'b1, 1'b0, 3'b100, b, {1'b0, ap, 10'h02A});
  endtask
  task automatic pre(string req, logic [1:0] b);
    issue(req, 1'b1, 1'b0, 3'b010, b, 12'h000);
  endtask
  task automatic preall(string req);
    issue(req, 1'b1, 1'b0, 3'b010, 2'd3, 12'h400);
  endtask
  task automatic mrs(string req, logic [11:0] key);
    issue(req, 1'b1, 1'b0, 3'b000, 2'd0, key);
  endtask

  task automatic doReset(string req);
    rstN = 1'b0;
    cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = 3'b111; ba = '0; addr = '0;
    repeat (3) @(negedge clk);
    modelReset();
    compareAll(req);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset("R11");
    nops("R11", 3);
    // R9: command right after mode set
    mrs("R9", 12'h002);
    act("R9", 2'd0, 12'h111);
    nops("R9", 3);
    preall("R3");
    nops("R3", 2);
    // R11: reset clears the sticky vector
    doReset("R11");
    mrs("R9", 12'h002);
    nops("R9", 2);
    // R1: chip select high with activate encoding, burst stop
    issue("R1", 1'b1, 1'b1, 3'b011, 2'd1, 12'h777);
    issue("R1", 1'b1, 1'b0, 3'b110, 2'd0, 12'h000);
    nops("R1", 1);
    // R2: open rows in two banks
    act("R2", 2'd2, 12'h5A5);
    nops("R2", 1);
    act("R2", 2'd1, 12'h3C3);
    nops("R2", 2);
    rd("R5", 2'd1, 1'b0);
    // R5: early read and read of closed bank
    act("R5", 2'd3, 12'h0F0);
    rd("R5", 2'd3, 1'b0);
    rd("R5", 2'd0, 1'b0);
    // R6: activate open bank, tRP, tRRD
    act("R6", 2'd3, 12'h0F1);
    nops("R6", 8);
    pre("R3", 2'd2);
    act("R6", 2'd2, 12'h222);
    act("R6", 2'd0, 12'h333);
    // R7: write recovery and row active time
    wr("R7", 2'd1, 1'b0);
    nops("R7", 1);
    pre("R7", 2'd1);
    pre("R7", 2'd0);
    nops("R7", 3);
    preall("R3");
    nops("R3", 3);
    // R8: refresh and mode set with an open bank
    act("R8", 2'd1, 12'h444);
    issue("R8", 1'b1, 1'b0, 3'b001, 2'd0, 12'h000);
    mrs("R8", 12'h002);
    nops("R8", 8);
    pre("R3", 2'd1);
    nops("R3", 3);
    issue("R4", 1'b1, 1'b0, 3'b001, 2'd0, 12'h000);
    nops("R4", 7);
    // R10: auto precharge on read and write
    act("R10", 2'd2, 12'h555);
    nops("R10", 2);
    rd("R10", 2'd2, 1'b1);
    nops("R10", 6);
    act("R10", 2'd2, 12'h556);
    nops("R10", 3);
    wr("R10", 2'd2, 1'b1);
    nops("R10", 9);
    mrs("R10", 12'h203);
    nops("R10", 2);
    act("R10", 2'd3, 12'h666);
    nops("R10", 2);
    wr("R10", 2'd3, 1'b1);
    nops("R10", 5);
    // R4: self refresh entry, ignored commands, exit spacing
    issue("R4", 1'b0, 1'b0, 3'b001, 2'd0, 12'h000);
    issue("R4", 1'b0, 1'b0, 3'b011, 2'd0, 12'h123);
    issue("R4", 1'b0, 1'b0, 3'b011, 2'd1, 12'h124);
    issue("R4", 1'b1, 1'b0, 3'b011, 2'd2, 12'h125);
    act("R4", 2'd0, 12'h126);
    nops("R4", 8);
    issue("R4", 1'b0, 1'b1, 3'b111, 2'd0, 12'h000);
    act("R4", 2'd1, 12'h127);
    nops("R4", 4);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule